// File: doc/BRIEF.md
# Destination Address Match Filter

This block watches the byte stream of each received frame, gathers the six destination address bytes that open it, and compares that 48-bit address against a small bank of programmable address slots. One clock after the sixth address byte it reports three things: that a comparison took place, whether any enabled slot matched, and the index of the lowest-numbered matching slot.

Each slot holds two registers on a simple write/read register bus. The bottom register is 32 bits and the top register keeps 16 bits. Software writes the bottom register first and the top register second.

Writing the bottom register switches the slot's matching off. Writing the top register switches it back on. Because of this, a slot whose address has only been half updated can never produce a hit. Slots may be rewritten at any moment, including in the middle of a frame.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset every slot reads back zero, every slot is disabled, and `match_valid` is low. An all-zero address therefore produces no hit until a slot's top register has been written.
- R2: Register address `{slot, half}` selects a register: half 0 is the 32-bit bottom register and half 1 is the top register. Only bits [15:0] of the top register are stored, and bits [31:16] of the top register always read as zero.
- R3: A write to a slot's bottom register disables matching for that slot from the next clock on.
- R4: A write to a slot's top register enables matching for that slot from the next clock on.
- R5: The first received address byte is compared with bits [7:0] of the bottom register, the fourth with bits [31:24], the fifth with top bits [7:0] and the sixth with top bits [15:8]. For example, 21:43:65:87:A9:CB matches bottom 0x87654321 and top 0x0000CBA9.
- R6: `match_valid` is high for exactly one clock, on the clock after the cycle that carries the sixth address byte.
- R7: When several enabled slots match, `match_slot` gives the lowest index. When none matches, `match_hit` and `match_slot` are zero.
- R8: A byte with `rx_sof` high starts a new address, even in the middle of one. Cycles with `rx_valid` low are skipped. Bytes after the sixth, and bytes received with no start of frame, are ignored.
- R9: The comparison uses the slot contents and enables as they stand in the cycle of the sixth byte, so a bottom write in the middle of a frame suppresses a hit on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SLOT_W+1 | Register select {slot, half}; used for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_data | input | 8 | Received byte |
| match_valid | output | 1 | One-clock pulse after the sixth address byte |
| match_hit | output | 1 | An enabled slot matched |
| match_slot | output | SLOT_W | Lowest matching slot index |

## Verification
Directed frames are used for the following cases:
- The worked example address, and the same address with its bytes reversed. These separate correct byte order from a swapped or mirrored comparison.
- Two slots holding identical addresses. This exposes a wrong priority order.
- A bottom-only write followed later by a top write, both between frames and in the middle of a frame. This tells a working enable sequence from one that ignores either half.
- Gapped bytes, a restarted start of frame, trailing bytes and bytes with no start of frame. These probe how the address bytes are framed.

Random frames, aimed either at programmed slot addresses or at fresh values, are mixed with random full and partial slot writes. They are checked against a bench model, which covers combinations that the directed cases do not reach.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int REG_W     = 32;
    localparam int LO_W      = 32;
    localparam int HI_W      = MAC_W - LO_W;
    localparam int CNT_W     = $clog2(MAC_BYTES + 1);

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } slot_addr_t;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic [7:0] data;
    } rx_byte_t;

    // First byte on the wire lands in the low byte of the bottom register.
    function automatic mac_t slot_mac(slot_addr_t s);
        return {s.hi, s.lo};
    endfunction
endpackage

// File: rtl/daf_slot_regs.sv
module daf_slot_regs
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SLOT_W:0]      reg_addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output slot_addr_t           slots [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0] slot_en
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [SLOT_W:0] BOT_A = (SLOT_W+1)'(2 * i);
        localparam logic [SLOT_W:0] TOP_A = (SLOT_W+1)'(2 * i + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i]   <= '0;
                slot_en[i] <= 1'b0;
            end else if (wr_en && reg_addr == BOT_A) begin
                slots[i].lo <= wr_data[LO_W-1:0];
                slot_en[i]  <= 1'b0;
            end else if (wr_en && reg_addr == TOP_A) begin
                slots[i].hi <= wr_data[HI_W-1:0];
                slot_en[i]  <= 1'b1;
            end
        end

        // R3
        bot_wr_disables_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && reg_addr == BOT_A) |=> !slot_en[i]);
        // R4
        top_wr_enables_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && reg_addr == TOP_A) |=> slot_en[i]);
        // R1
        reset_disables_chk: assert property (@(posedge clk)
            rst |=> (!slot_en[i] && slots[i] == '0));
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (reg_addr[SLOT_W:1] == SLOT_W'(k)) begin
                rd_data = reg_addr[0] ? {{(REG_W-HI_W){1'b0}}, slots[k].hi}
                                      : slots[k].lo;
            end
        end
    end

    // R2
    always_ff @(posedge clk) begin
        if (!rst) begin
            top_upper_zero_chk: assert (!reg_addr[0] || rd_data[REG_W-1:HI_W] == '0);
        end
    end
endmodule

// File: rtl/daf_addr_collect.sv
module daf_addr_collect
    import daf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_byte_t rx,
    output mac_t     cur_mac,
    output logic     fire
);
    logic [CNT_W-1:0]   cnt;
    logic [MAC_W-9:0]   held;

    // cnt == 0: waiting for a start of frame; otherwise bytes already held.
    assign fire    = rx.valid && !rx.sof && cnt == CNT_W'(MAC_BYTES - 1);
    assign cur_mac = {rx.data, held};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (rx.valid && rx.sof) begin
            held[7:0] <= rx.data;
            cnt       <= CNT_W'(1);
        end else if (rx.valid && cnt != '0) begin
            if (fire) begin
                cnt <= '0;
            end else begin
                held[8*cnt +: 8] <= rx.data;
                cnt              <= cnt + 1'b1;
            end
        end
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(MAC_BYTES));
endmodule

// File: rtl/daf_match_sel.sv
module daf_match_sel
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  mac_t                 cur_mac,
    input  slot_addr_t           slots [NUM_SLOTS],
    input  logic [NUM_SLOTS-1:0] slot_en,
    output logic                 match_valid,
    output logic                 match_hit,
    output logic [SLOT_W-1:0]    match_slot
);
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [SLOT_W-1:0]    first_idx;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hit_vec[i] = slot_en[i] && (slot_mac(slots[i]) == cur_mac);
    end

    always_comb begin
        first_idx = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (hit_vec[k]) first_idx = SLOT_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
            match_slot  <= '0;
        end else begin
            match_valid <= fire;
            match_hit   <= fire && (hit_vec != '0);
            match_slot  <= fire ? first_idx : '0;
        end
    end

    // R6
    valid_follows_fire_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(fire));
    // R6
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);
    // R7
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && slot_en == '0) |=> !match_hit);
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int  NUM_SLOTS = 4,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SLOT_W:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_data,
    output logic              match_valid,
    output logic              match_hit,
    output logic [SLOT_W-1:0] match_slot
);
    slot_addr_t           slots [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_en;
    rx_byte_t             rx;
    mac_t                 cur_mac;
    logic                 fire;

    assign rx = '{valid: rx_valid, sof: rx_sof, data: rx_data};

    daf_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .reg_addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .slots(slots), .slot_en(slot_en)
    );

    daf_addr_collect u_collect (
        .clk(clk), .rst(rst), .rx(rx), .cur_mac(cur_mac), .fire(fire)
    );

    daf_match_sel #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_sel (
        .clk(clk), .rst(rst), .fire(fire), .cur_mac(cur_mac), .slots(slots),
        .slot_en(slot_en), .match_valid(match_valid), .match_hit(match_hit),
        .match_slot(match_slot)
    );

    // R1
    no_match_in_reset_chk: assert property (@(posedge clk)
        rst |=> !match_valid);
endmodule

// File: tb/sim_dst_addr_filter.sv
module sim_dst_addr_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        match_valid, match_hit;
    logic [1:0]  match_slot;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_lo [4];
    logic [15:0] m_hi [4];
    bit          m_en [4];

    always #2 clk = ~clk;

    dst_addr_filter #(.NUM_SLOTS(4)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_data(rx_data), .match_valid(match_valid),
        .match_hit(match_hit), .match_slot(match_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input bit s, input logic [7:0] d,
                       input bit w, input logic [2:0] a, input logic [31:0] wd);
        @(negedge clk);
        rx_valid = v; rx_sof = s; rx_data = d;
        reg_wr = w; reg_addr = a; reg_wdata = wd;
    endtask

    task automatic idle();
        cyc(0, 0, 8'h0, 0, 3'd0, 32'h0);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        cyc(0, 0, 8'h0, 1, a, d);
        if (a[0]) begin m_hi[a[2:1]] = d[15:0]; m_en[a[2:1]] = 1; end
        else      begin m_lo[a[2:1]] = d;       m_en[a[2:1]] = 0; end
    endtask

    task automatic write_slot(input int k, input logic [47:0] mac);
        wr_reg(3'(2*k), mac[31:0]);
        wr_reg(3'(2*k+1), {16'h0, mac[47:32]});
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        cyc(0, 0, 8'h0, 0, a, 32'h0);
        #1 chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    function automatic logic [2:0] exp_match(input logic [47:0] mac);
        for (int k = 0; k < 4; k++)
            if (m_en[k] && {m_hi[k], m_lo[k]} == mac) return {1'b1, 2'(k)};
        return 3'b000;
    endfunction

    task automatic push_mac(input logic [47:0] mac, input int gap_pct);
        for (int i = 0; i < 6; i++) begin
            cyc(1, i == 0, mac[8*i +: 8], 0, 3'd0, 32'h0);
            if (i < 5 && ($urandom % 100) < gap_pct) idle();
        end
    endtask

    task automatic check_match(input logic [2:0] exp, input string req);
        idle();
        chk(match_valid === 1'b1, req, match_valid, 1);
        chk({match_hit, match_slot} === exp, req, {match_hit, match_slot}, exp);
        idle();
        chk(match_valid === 1'b0, "R6", match_valid, 0);
    endtask

    task automatic frame(input logic [47:0] mac, input int gap_pct, input string req);
        push_mac(mac, gap_pct);
        check_match(exp_match(mac), req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [47:0] ex, pool [3];
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 4; k++) begin m_lo[k] = 0; m_hi[k] = 0; m_en[k] = 0; end
        for (int k = 0; k < 3; k++) pool[k] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk(match_valid === 1'b0, "R1", match_valid, 0);
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1");
        frame(48'h0, 0, "R1");

        // R2 readback, upper top bits dropped
        ex = 48'hCBA9_8765_4321;
        wr_reg(3'd2, 32'h8765_4321);
        wr_reg(3'd3, 32'hFFFF_CBA9);
        rd_chk(3'd2, 32'h8765_4321, "R2");
        rd_chk(3'd3, 32'h0000_CBA9, "R2");

        // R5 byte order: example hits slot 1, reversed misses
        frame(ex, 0, "R5");
        frame(48'h2143_6587_A9CB, 0, "R5");

        // R7 priority: slots 2 and 3 identical, slot 0 different
        write_slot(0, pool[0]);
        write_slot(2, pool[1]);
        write_slot(3, pool[1]);
        frame(pool[1], 0, "R7");
        // R3 bottom-only write disables slot 2, slot 3 takes over
        wr_reg(3'd4, pool[1][31:0]);
        frame(pool[1], 0, "R3");
        // R4 top write re-enables slot 2
        wr_reg(3'd5, {16'h0, pool[1][47:32]});
        frame(pool[1], 0, "R4");

        // R9 mid-frame bottom write suppresses the hit on slot 1
        for (int i = 0; i < 3; i++) cyc(1, i == 0, ex[8*i +: 8], 0, 3'd0, 32'h0);
        wr_reg(3'd2, ex[31:0]);
        for (int i = 3; i < 6; i++) cyc(1, 0, ex[8*i +: 8], 0, 3'd0, 32'h0);
        check_match(3'b000, "R9");
        wr_reg(3'd3, {16'h0, ex[47:32]});
        frame(ex, 50, "R9");

        // R8 restart on sof mid-address
        for (int i = 0; i < 3; i++) cyc(1, i == 0, pool[2][8*i +: 8], 0, 3'd0, 32'h0);
        push_mac(ex, 0);
        check_match(3'b101, "R8");
        // R8 trailing bytes ignored
        push_mac(ex, 0);
        cyc(1, 0, 8'h21, 0, 3'd0, 32'h0);
        chk(match_valid === 1'b1 && match_slot === 2'd1, "R8", {match_valid, match_slot}, 3'b101);
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, ex[8*i +: 8], 0, 3'd0, 32'h0);
            chk(match_valid === 1'b0, "R8", match_valid, 0);
        end
        // R8 bytes with no start of frame ignored
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0, ex[8*i +: 8], 0, 3'd0, 32'h0);
            chk(match_valid === 1'b0, "R8", match_valid, 0);
        end
        idle();
        chk(match_valid === 1'b0, "R8", match_valid, 0);

        // Random mix of writes and frames
        for (int it = 0; it < 400; it++) begin
            int op, k;
            logic [47:0] m;
            op = $urandom % 6;
            k = $urandom % 4;
            m = ($urandom % 2) ? pool[$urandom % 3] : {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            case (op)
                0: write_slot(k, m);
                1: wr_reg(3'(2*k), m[31:0]);
                2: wr_reg(3'(2*k+1), {$urandom} );
                3: rd_chk(3'(2*k + (it % 2)), (it % 2) ? {16'h0, m_hi[k]} : m_lo[k], "R2");
                default: begin
                    if (($urandom % 2) && m_en[k]) m = {m_hi[k], m_lo[k]};
                    frame(m, 30, "R7");
                end
            endcase
        end

        summary();
    end
endmodule